// File: doc/BRIEF.md
# Delayed Completion Discard Timer

This block sits beside the delayed-completion queue on the secondary side of a bus bridge. It measures how long a queued completion has been waiting for its requester to retry. When a completion is queued, a cycle counter starts. A claim by the requester stops and clears the counter. If the counter reaches the selected limit first, the block emits a one-cycle discard pulse, which tells the queue logic to drop the entry. It also latches a sticky expiry flag.

Software sets up the block through a simple write port. One bit chooses a short limit (2^10 secondary clock cycles) or a long limit (2^15). One bit enables error signalling. Writing 1 to the status position clears the expiry flag. The error signal takes one of two forms, chosen by the bridge direction input. In the forward direction it is an active-high request for an error message. In the reverse direction it drives an active-low system error line. When the secondary bus runs in PCI-X mode, no error signalling takes place.

Top module: `dcd_timer`

## Requirements
- R1: After reset, discard_o, status_o and err_msg_o are 0 and sys_err_n_o is 1. The short-limit select and the error enable are both 0, so a completion queued before any configuration write expires after 2^15 cycles and raises no error.
- R2: With the select (cfg_wdata_i bit 0) at 0, discard_o rises exactly 2^15 clock cycles after the clock edge that samples cpl_queued_i high. It stays high for one cycle.
- R3: With the select at 1, discard_o rises exactly 2^10 cycles after the queued strobe is sampled, for one cycle.
- R4: A cpl_claimed_i strobe sampled before expiry stops the count, and no discard follows. A claim sampled on the very edge where the limit would be reached wins over the expiry.
- R5: A new cpl_queued_i strobe while a count is running restarts the count from zero.
- R6: status_o becomes 1 in the same cycle as discard_o and stays 1 until it is cleared.
- R7: A configuration write with cfg_wdata_i bit 1 set clears status_o. A write with that bit at 0 leaves status_o unchanged. When an expiry and a clearing write fall on the same edge, status_o ends up 1.
- R8: With the error enable (cfg_wdata_i bit 2) at 1, fwd_mode_i at 1 and pcix_mode_i at 0, err_msg_o pulses high for one cycle together with discard_o.
- R9: With the error enable at 1, fwd_mode_i at 0 and pcix_mode_i at 0, sys_err_n_o goes low for one cycle together with discard_o.
- R10: When pcix_mode_i is 1 or the error enable is 0, an expiry leaves err_msg_o at 0 and sys_err_n_o at 1.
- R11: After an expiry the counter is idle. No further discard occurs until another completion is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Secondary bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpl_queued_i | input | 1 | Strobe: a delayed completion was queued |
| cpl_claimed_i | input | 1 | Strobe: the requester collected the completion |
| cfg_wr_i | input | 1 | Configuration write enable |
| cfg_wdata_i | input | 3 | Write data: bit 0 short-limit select, bit 1 clear status, bit 2 error enable |
| fwd_mode_i | input | 1 | 1 = forward bridge direction, 0 = reverse |
| pcix_mode_i | input | 1 | 1 = secondary bus in PCI-X mode |
| discard_o | output | 1 | One-cycle pulse: drop the waiting completion |
| status_o | output | 1 | Sticky expiry flag |
| err_msg_o | output | 1 | One-cycle error message request (forward direction) |
| sys_err_n_o | output | 1 | Active-low system error, low for one cycle (reverse direction) |

## Verification
On every cycle, the properties check several invariants. The discard pulse lasts a single cycle and is never issued earlier than the short limit after the last queue strobe. A claim suppresses the next-cycle discard. The status flag follows its set, sticky and clear rules. Each error output fires only alongside a discard and in the correct direction, and never in PCI-X mode. The exact expiry cycle for each limit, the reset defaults of the select and enable, the restart on re-queue, the final-edge claim and the set-over-clear collision depend on long counted scenarios, so only the bench's vector table and directed runs can show them.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    // Configuration write-data field positions
    localparam int unsigned CFG_W        = 3;
    localparam int unsigned CFG_SHORT    = 0;
    localparam int unsigned CFG_CLR_STAT = 1;
    localparam int unsigned CFG_ERR_EN   = 2;

    typedef struct packed {
        logic short_sel;
        logic err_en;
    } cfg_t;

    typedef struct packed {
        logic msg;
        logic sys_err_n;
    } err_t;

endpackage

// File: rtl/dcd_cfg.sv
module dcd_cfg
    import dcd_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [CFG_W-1:0] wdata_i,
    output cfg_t             cfg_o
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i) begin
            cfg_d.short_sel = wdata_i[CFG_SHORT];
            cfg_d.err_en    = wdata_i[CFG_ERR_EN];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/dcd_counter.sv
module dcd_counter #(
    parameter int unsigned LONG_EXP  = 15,
    parameter int unsigned SHORT_EXP = 10
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic queued_i,
    input  logic claimed_i,
    input  logic short_sel_i,
    output logic expire_o,
    output logic discard_o
);

    localparam int unsigned CNT_W = LONG_EXP;
    localparam logic [CNT_W-1:0] LONG_LAST  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'((64'd1 << SHORT_EXP) - 64'd1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic             discard;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W-1:0] last;
    logic             expire;

    assign last = short_sel_i ? SHORT_LAST : LONG_LAST;

    always_comb begin
        st_d         = st_q;
        st_d.discard = 1'b0;
        expire       = 1'b0;
        if (queued_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (claimed_i) begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (st_q.cnt >= last) begin
                expire       = 1'b1;
                st_d.active  = 1'b0;
                st_d.cnt     = '0;
                st_d.discard = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign expire_o  = expire;
    assign discard_o = st_q.discard;

endmodule

// File: rtl/dcd_status.sv
module dcd_status (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic status_o
);

    logic stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (clr_i) stat_d = 1'b0;
        if (set_i) stat_d = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stat_q <= 1'b0;
        else         stat_q <= stat_d;
    end

    assign status_o = stat_q;

endmodule

// File: rtl/dcd_err.sv
module dcd_err
    import dcd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic expire_i,
    input  logic err_en_i,
    input  logic fwd_i,
    input  logic pcix_i,
    output err_t err_o
);

    err_t err_d, err_q;
    logic fire;

    assign fire = expire_i && err_en_i && !pcix_i;

    always_comb begin
        err_d.msg       = fire && fwd_i;
        err_d.sys_err_n = !(fire && !fwd_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            err_q.msg       <= 1'b0;
            err_q.sys_err_n <= 1'b1;
        end else begin
            err_q <= err_d;
        end
    end

    assign err_o = err_q;

endmodule

// File: rtl/dcd_timer.sv
module dcd_timer
    import dcd_pkg::*;
#(
    parameter int unsigned LONG_EXP  = 15,
    parameter int unsigned SHORT_EXP = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cpl_queued_i,
    input  logic             cpl_claimed_i,
    input  logic             cfg_wr_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    input  logic             fwd_mode_i,
    input  logic             pcix_mode_i,
    output logic             discard_o,
    output logic             status_o,
    output logic             err_msg_o,
    output logic             sys_err_n_o
);

    cfg_t cfg;
    err_t err;
    logic expire;

    dcd_cfg u_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (cfg_wr_i),
        .wdata_i (cfg_wdata_i),
        .cfg_o   (cfg)
    );

    dcd_counter #(
        .LONG_EXP  (LONG_EXP),
        .SHORT_EXP (SHORT_EXP)
    ) u_cnt (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .queued_i    (cpl_queued_i),
        .claimed_i   (cpl_claimed_i),
        .short_sel_i (cfg.short_sel),
        .expire_o    (expire),
        .discard_o   (discard_o)
    );

    dcd_status u_stat (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (expire),
        .clr_i    (cfg_wr_i && cfg_wdata_i[CFG_CLR_STAT]),
        .status_o (status_o)
    );

    dcd_err u_err (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .expire_i (expire),
        .err_en_i (cfg.err_en),
        .fwd_i    (fwd_mode_i),
        .pcix_i   (pcix_mode_i),
        .err_o    (err)
    );

    assign err_msg_o   = err.msg;
    assign sys_err_n_o = err.sys_err_n;

endmodule

// File: rtl/dcd_timer_chk.sv
module dcd_timer_chk
    import dcd_pkg::*;
#(
    parameter int unsigned SHORT_EXP = 10
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             cpl_queued_i,
    input logic             cpl_claimed_i,
    input logic             cfg_wr_i,
    input logic [CFG_W-1:0] cfg_wdata_i,
    input logic             fwd_mode_i,
    input logic             pcix_mode_i,
    input logic             discard_o,
    input logic             status_o,
    input logic             err_msg_o,
    input logic             sys_err_n_o
);

    localparam int unsigned SHORT_LIM = 1 << SHORT_EXP;

    // Cycles since the last sampled queue strobe (saturating)
    int unsigned age_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              age_q <= 0;
        else if (cpl_queued_i)    age_q <= 0;
        else if (age_q < 32'hFFFF_FFF0) age_q <= age_q + 1;
    end

    p_disc_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        discard_o |=> !discard_o);

    p_min_age_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        discard_o |-> (age_q >= SHORT_LIM));

    p_claim_kills_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cpl_claimed_i && !cpl_queued_i) |=> !discard_o);

    p_status_on_disc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        discard_o |-> status_o);

    p_status_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o && !(cfg_wr_i && cfg_wdata_i[CFG_CLR_STAT])) |=> status_o);

    p_status_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_wr_i && cfg_wdata_i[CFG_CLR_STAT]) |=> (!status_o || discard_o));

    p_msg_fwd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_msg_o |-> (discard_o && $past(fwd_mode_i)));

    p_syserr_rev_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sys_err_n_o |-> (discard_o && !$past(fwd_mode_i)));

    p_pcix_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(pcix_mode_i) |-> (sys_err_n_o && !err_msg_o));

    p_err_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(err_msg_o && !sys_err_n_o));

endmodule

bind dcd_timer dcd_timer_chk #(.SHORT_EXP(SHORT_EXP)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cpl_queued_i  (cpl_queued_i),
    .cpl_claimed_i (cpl_claimed_i),
    .cfg_wr_i      (cfg_wr_i),
    .cfg_wdata_i   (cfg_wdata_i),
    .fwd_mode_i    (fwd_mode_i),
    .pcix_mode_i   (pcix_mode_i),
    .discard_o     (discard_o),
    .status_o      (status_o),
    .err_msg_o     (err_msg_o),
    .sys_err_n_o   (sys_err_n_o)
);

// File: tb/tb_dcd_timer.sv
`timescale 1ns/1ps
module tb_dcd_timer;

    localparam int LONG_LIM  = 32768;
    localparam int SHORT_LIM = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       queued = 1'b0;
    logic       claimed = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_wdata = '0;
    logic       fwd = 1'b1;
    logic       pcix = 1'b0;
    logic       discard, status, err_msg, sys_err_n;

    int n_checks = 0;
    int n_err    = 0;

    always #10 clk = ~clk;

    dcd_timer dut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .cpl_queued_i  (queued),
        .cpl_claimed_i (claimed),
        .cfg_wr_i      (cfg_wr),
        .cfg_wdata_i   (cfg_wdata),
        .fwd_mode_i    (fwd),
        .pcix_mode_i   (pcix),
        .discard_o     (discard),
        .status_o      (status),
        .err_msg_o     (err_msg),
        .sys_err_n_o   (sys_err_n)
    );

    typedef struct packed {
        logic        sel;
        logic        en;
        logic        fwd;
        logic        pcix;
        logic [15:0] claim_k;
        logic        exp_disc;
        logic        exp_msg;
        logic        exp_serr;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b0, 1'b0, 1'b1, 1'b0, 16'd0,    1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b1, 1'b0, 16'd0,    1'b1, 1'b1, 1'b0},
        '{1'b1, 1'b1, 1'b0, 1'b0, 16'd0,    1'b1, 1'b0, 1'b1},
        '{1'b1, 1'b1, 1'b1, 1'b1, 16'd0,    1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b0, 1'b1, 16'd0,    1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b1, 1'b0, 16'd500,  1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b0, 1'b0, 16'd1024, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b0, 1'b0, 16'd0,    1'b1, 1'b0, 1'b1},
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'd0,    1'b1, 1'b0, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] data);
        cfg_wr    = 1'b1;
        cfg_wdata = data;
        @(posedge clk);
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic pulse_queue();
        queued = 1'b1;
        @(posedge clk);
        @(negedge clk);
        queued = 1'b0;
    endtask

    // Runs maxk cycles after a queue strobe; k counts edges since it
    task automatic watch(input int maxk, input int claim_k, output int first,
                         output int ndisc, output int nmsg, output int nserr);
        first = -1; ndisc = 0; nmsg = 0; nserr = 0;
        for (int k = 1; k <= maxk; k++) begin
            claimed = (k == claim_k);
            @(posedge clk);
            @(negedge clk);
            claimed = 1'b0;
            if (discard) begin
                ndisc++;
                if (first < 0) first = k;
            end
            if (err_msg)    nmsg++;
            if (!sys_err_n) nserr++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int first, ndisc, nmsg, nserr, lim;
        string req;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values at the ports
        check(discard == 1'b0,   "R1 discard", discard, 0);
        check(status == 1'b0,    "R1 status", status, 0);
        check(err_msg == 1'b0,   "R1 err_msg", err_msg, 0);
        check(sys_err_n == 1'b1, "R1 sys_err_n", sys_err_n, 1);

        // R1: defaults give long limit and no error (reverse direction)
        fwd = 1'b0;
        pulse_queue();
        watch(LONG_LIM + 5, 0, first, ndisc, nmsg, nserr);
        check(first == LONG_LIM, "R1 default limit", first, LONG_LIM);
        check(nserr == 0, "R1 default err enable", nserr, 0);

        // Vector table
        foreach (VECS[i]) begin
            fwd  = VECS[i].fwd;
            pcix = VECS[i].pcix;
            cfg_write({VECS[i].en, 1'b1, VECS[i].sel});
            check(status == 1'b0, "R7 clear before run", status, 0);
            pulse_queue();
            lim = VECS[i].sel ? SHORT_LIM : LONG_LIM;
            watch(lim + 40, int'(VECS[i].claim_k), first, ndisc, nmsg, nserr);
            req = (VECS[i].claim_k != 0) ? "R4" : (VECS[i].sel ? "R3" : "R2");
            check(first == (VECS[i].exp_disc ? lim : -1), req, first,
                  VECS[i].exp_disc ? lim : -1);
            check(ndisc == int'(VECS[i].exp_disc), "R11 single discard", ndisc,
                  int'(VECS[i].exp_disc));
            check(nmsg == int'(VECS[i].exp_msg), "R8/R10 err_msg", nmsg,
                  int'(VECS[i].exp_msg));
            check(nserr == int'(VECS[i].exp_serr), "R9/R10 sys_err_n", nserr,
                  int'(VECS[i].exp_serr));
            check(status == VECS[i].exp_disc, "R6 status", status,
                  int'(VECS[i].exp_disc));
        end

        // R5: re-queue during a count restarts it
        fwd = 1'b1; pcix = 1'b0;
        cfg_write(3'b011);
        pulse_queue();
        watch(600, 0, first, ndisc, nmsg, nserr);
        check(ndisc == 0, "R5 no early discard", ndisc, 0);
        pulse_queue();
        watch(SHORT_LIM + 5, 0, first, ndisc, nmsg, nserr);
        check(first == SHORT_LIM, "R5 restart", first, SHORT_LIM);

        // R7: write with clear bit 0 keeps status; with 1 clears it
        cfg_write(3'b001);
        check(status == 1'b1, "R7 write zero keeps", status, 1);
        cfg_write(3'b011);
        check(status == 1'b0, "R7 write one clears", status, 0);

        // R7: expiry and clearing write on the same edge -> set wins
        pulse_queue();
        watch(SHORT_LIM - 1, 0, first, ndisc, nmsg, nserr);
        check(ndisc == 0, "R7 pre-collision", ndisc, 0);
        cfg_wr    = 1'b1;
        cfg_wdata = 3'b011;
        @(posedge clk);
        @(negedge clk);
        cfg_wr    = 1'b0;
        check(discard == 1'b1, "R7 collision discard", discard, 1);
        check(status == 1'b1, "R7 set wins", status, 1);
        @(negedge clk);
        check(status == 1'b1, "R7 set holds", status, 1);
        check(discard == 1'b0, "R11 idle after expiry", discard, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule